// File: doc/BRIEF.md
# Triplicated Scrubbed Register Voter

This block is a fault-tolerant register stage of configurable width. It keeps three identical copies of the stored word. Every copy is loaded from the same input beat with the same load strobe. Three separate two-of-three majority voters read the copies. Each voter drives its own output lane, so a following stage that is also triplicated can take one lane per copy, and a single broken voter affects only one lane. No single voter sits on the path of all three lanes.

A free-running timer raises a scrub tick every `SCRUB_INTERVAL` cycles. On that tick, each copy is rewritten from the output of its own voter. A single upset is therefore cleared before a second upset can land on the same bit of another copy. Each copy has a test-only injection strobe and mask that flip chosen stored bits, so upsets can be emulated. A registered 3-bit flag vector shows which copies disagree with their voter.

The input side uses a valid/ready handshake. The stage never applies back-pressure: ready is held high and a beat is taken on every cycle that valid is high. The output lanes have no handshake. They always show the voted state.

Top module: `tmr_scrub_reg`

## Requirements
- R1: `in_ready` is always 1. A cycle with `in_valid` high writes `in_data` into all three copies at that clock edge, so every lane shows `in_data` after the edge.
- R2: Each output lane `i` (bits `[i*DATA_W +: DATA_W]` of `out_lanes`) is, bit by bit, 1 when at least two of the three copy bits are 1, and 0 otherwise.
- R3: When at most one copy holds a wrong value in a bit, all three lanes show the correct value for that bit.
- R4: When `inj_en[i]` is high, the next value of copy `i` (whether loaded, scrubbed or held) is XORed with `inj_mask[i*DATA_W +: DATA_W]` at that edge.
- R5: The scrub timer counts from 0 after reset and ticks on every cycle where its count equals `SCRUB_INTERVAL-1`, then wraps to 0. The first tick edge is therefore the `SCRUB_INTERVAL`-th edge after reset is released. On a tick without a load, each copy takes its own lane's vote, which clears a single corrupted copy.
- R6: A load on the same cycle as a scrub tick wins: the copies take `in_data`, not the vote.
- R7: A synchronous active-high `rst` clears all three copies, the scrub timer and the mismatch flags to zero, and overrides a load in the same cycle.
- R8: `mismatch[i]` is a register. At the edge that ends a cycle, it becomes 1 if copy `i` differed on any bit from lane `i`'s vote during that cycle.
- R9: If two or more copies are wrong on the same bit, all lanes follow the wrong majority. This is an uncorrectable case, and the mismatch flag then marks the one copy that still holds the correct value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat valid / load strobe |
| in_ready | output | 1 | Always 1; the stage never stalls |
| in_data | input | DATA_W | Word loaded into all three copies |
| inj_en | input | 3 | Per-copy upset injection strobe |
| inj_mask | input | 3*DATA_W | Per-copy XOR masks, copy `i` at `[i*DATA_W +: DATA_W]` |
| out_lanes | output | 3*DATA_W | Three voted lanes, lane `i` at `[i*DATA_W +: DATA_W]` |
| mismatch | output | 3 | Registered per-copy disagreement flags |

## Verification
Only the votes reach the ports directly. A single copy holding a wrong bit is masked in the lanes, so that fault shows up only as a mismatch flag, one edge after it forms. A lost scrub write-back stays hidden until a later upset lands on the same bit of a second copy. At that point the lanes flip, one edge after the second upset. A timer off by a cycle shifts when the flag clears, and it also decides whether a load or a scrub wins on a tick cycle. The bench tracks the expected copies cycle by cycle and compares every lane and flag at every sampled cycle. Directed sequences line up upsets against the tick so that these hidden faults become visible at the ports.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned NCOPY = 3;

  typedef enum logic [1:0] {
    NXT_HOLD  = 2'd0,
    NXT_LOAD  = 2'd1,
    NXT_SCRUB = 2'd2
  } nxt_src_e;
endpackage

// File: rtl/tmr_copy_reg.sv
module tmr_copy_reg
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              scrub,
  input  logic [DATA_W-1:0] scrub_data,
  input  logic              inj,
  input  logic [DATA_W-1:0] inj_bits,
  output logic [DATA_W-1:0] q
);
  nxt_src_e          src;
  logic [DATA_W-1:0] base;
  logic [DATA_W-1:0] flip;

  // load outranks scrub; scrub outranks hold
  always_comb begin
    if (load)       src = NXT_LOAD;
    else if (scrub) src = NXT_SCRUB;
    else            src = NXT_HOLD;
  end

  always_comb begin
    unique case (src)
      NXT_LOAD:  base = load_data;
      NXT_SCRUB: base = scrub_data;
      default:   base = q;
    endcase
  end

  assign flip = inj ? inj_bits : '0;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= base ^ flip;
  end
endmodule

// File: rtl/tmr_voter.sv
module tmr_voter #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [DATA_W-1:0] c,
  output logic [DATA_W-1:0] y
);
  // full-adder carry per bit
  assign y = (a & b) | (b & c) | (a & c);
endmodule

// File: rtl/tmr_scrub_timer.sv
module tmr_scrub_timer #(
  parameter int unsigned SCRUB_INTERVAL = 64
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  generate
    if (SCRUB_INTERVAL <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_count
      localparam int unsigned CNT_W = $clog2(SCRUB_INTERVAL);
      localparam logic [CNT_W-1:0] LAST = CNT_W'(SCRUB_INTERVAL - 1);
      logic [CNT_W-1:0] cnt;
      assign tick = (cnt == LAST);
      always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/tmr_mismatch.sv
module tmr_mismatch
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NCOPY-1:0][DATA_W-1:0] copies,
  input  logic [NCOPY-1:0][DATA_W-1:0] votes,
  output logic [NCOPY-1:0]             flags
);
  logic [NCOPY-1:0] diff;

  for (genvar i = 0; i < NCOPY; i++) begin : g_cmp
    assign diff[i] = |(copies[i] ^ votes[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= diff;
  end
endmodule

// File: rtl/tmr_scrub_reg.sv
module tmr_scrub_reg
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W         = 8,
  parameter int unsigned SCRUB_INTERVAL = 64
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [DATA_W-1:0]         in_data,
  input  logic [NCOPY-1:0]          inj_en,
  input  logic [NCOPY*DATA_W-1:0]   inj_mask,
  output logic [NCOPY*DATA_W-1:0]   out_lanes,
  output logic [NCOPY-1:0]          mismatch
);
  logic [NCOPY-1:0][DATA_W-1:0] copy_q;
  logic [NCOPY-1:0][DATA_W-1:0] lane_v;
  logic                         scrub_tick;

  assign in_ready = 1'b1;

  tmr_scrub_timer #(.SCRUB_INTERVAL(SCRUB_INTERVAL)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .tick (scrub_tick)
  );

  for (genvar i = 0; i < NCOPY; i++) begin : g_copy
    tmr_copy_reg #(.DATA_W(DATA_W)) u_reg (
      .clk        (clk),
      .rst        (rst),
      .load       (in_valid),
      .load_data  (in_data),
      .scrub      (scrub_tick),
      .scrub_data (lane_v[i]),
      .inj        (inj_en[i]),
      .inj_bits   (inj_mask[i*DATA_W +: DATA_W]),
      .q          (copy_q[i])
    );

    // one voter per lane, no shared voting logic
    tmr_voter #(.DATA_W(DATA_W)) u_vote (
      .a (copy_q[0]),
      .b (copy_q[1]),
      .c (copy_q[2]),
      .y (lane_v[i])
    );

    assign out_lanes[i*DATA_W +: DATA_W] = lane_v[i];
  end

  tmr_mismatch #(.DATA_W(DATA_W)) u_mis (
    .clk    (clk),
    .rst    (rst),
    .copies (copy_q),
    .votes  (lane_v),
    .flags  (mismatch)
  );
endmodule

// File: rtl/tmr_scrub_reg_chk.sv
module tmr_scrub_reg_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  in_valid,
  input logic                  in_ready,
  input logic [DATA_W-1:0]     in_data,
  input logic [2:0]            inj_en,
  input logic [3*DATA_W-1:0]   out_lanes,
  input logic [2:0]            mismatch,
  input logic [2:0][DATA_W-1:0] copy_q,
  input logic                  scrub_tick
);
  logic [DATA_W-1:0] l0, l1, l2, maj;
  assign l0  = out_lanes[0*DATA_W +: DATA_W];
  assign l1  = out_lanes[1*DATA_W +: DATA_W];
  assign l2  = out_lanes[2*DATA_W +: DATA_W];
  assign maj = (copy_q[0] & copy_q[1]) | (copy_q[0] & copy_q[2]) | (copy_q[1] & copy_q[2]);

  a_r1_always_ready: assert property (@(posedge clk) in_ready);

  a_r2_lanes_vote: assert property (@(posedge clk) disable iff (rst)
    (l0 == maj) && (l1 == maj) && (l2 == maj));

  a_r3_pair_masks: assert property (@(posedge clk) disable iff (rst)
    (copy_q[0] == copy_q[1]) |-> (l0 == copy_q[0] && l1 == copy_q[0] && l2 == copy_q[0]));

  a_r6_load_wins: assert property (@(posedge clk) disable iff (rst)
    (in_valid && inj_en == 3'b000) |=>
      (copy_q[0] == $past(in_data) && copy_q[1] == $past(in_data) && copy_q[2] == $past(in_data)));

  a_r5_scrub_aligns: assert property (@(posedge clk) disable iff (rst)
    (scrub_tick && !in_valid && inj_en == 3'b000) |=>
      (copy_q[0] == copy_q[1] && copy_q[1] == copy_q[2]));

  a_r7_reset_clears: assert property (@(posedge clk)
    rst |=> (copy_q == '0 && mismatch == 3'b000));

  a_r8_flag_copy0: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (mismatch[0] == $past(|(copy_q[0] ^ l0))));
  a_r8_flag_copy1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (mismatch[1] == $past(|(copy_q[1] ^ l1))));
  a_r8_flag_copy2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (mismatch[2] == $past(|(copy_q[2] ^ l2))));
endmodule

bind tmr_scrub_reg tmr_scrub_reg_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_data    (in_data),
  .inj_en     (inj_en),
  .out_lanes  (out_lanes),
  .mismatch   (mismatch),
  .copy_q     (copy_q),
  .scrub_tick (scrub_tick)
);

// File: tb/tmr_scrub_reg_bench.sv
`timescale 1ns/1ps
module tmr_scrub_reg_bench;
  localparam int W  = 4;
  localparam int SI = 8;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           in_valid = 1'b0;
  logic           in_ready;
  logic [W-1:0]   in_data = '0;
  logic [2:0]     inj_en = '0;
  logic [3*W-1:0] inj_mask = '0;
  logic [3*W-1:0] out_lanes;
  logic [2:0]     mismatch;

  int vectors = 0;
  int miscomp = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  tmr_scrub_reg #(.DATA_W(W), .SCRUB_INTERVAL(SI)) u_tmr_scrub_reg (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .inj_en(inj_en), .inj_mask(inj_mask),
    .out_lanes(out_lanes), .mismatch(mismatch)
  );

  // reference model built from the requirements
  logic [W-1:0] m_c0 = '0, m_c1 = '0, m_c2 = '0;
  int           m_cnt = 0;
  logic [2:0]   m_mis = '0;

  function automatic logic [W-1:0] vote3(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c);
    logic [W-1:0] r;
    for (int k = 0; k < W; k++) r[k] = ((a[k] + b[k] + c[k]) >= 2);
    return r;
  endfunction

  function automatic logic [W-1:0] nxt(logic [W-1:0] cur, logic [W-1:0] v, int idx);
    logic [W-1:0] b;
    if (in_valid)            b = in_data;
    else if (m_cnt == SI-1)  b = v;
    else                     b = cur;
    if (inj_en[idx]) b = b ^ inj_mask[idx*W +: W];
    return b;
  endfunction

  always @(posedge clk) begin
    logic [W-1:0] v;
    v = vote3(m_c0, m_c1, m_c2);
    if (rst) begin
      m_c0 <= '0; m_c1 <= '0; m_c2 <= '0; m_cnt <= 0; m_mis <= '0;
    end else begin
      m_c0  <= nxt(m_c0, v, 0);
      m_c1  <= nxt(m_c1, v, 1);
      m_c2  <= nxt(m_c2, v, 2);
      m_cnt <= (m_cnt == SI-1) ? 0 : m_cnt + 1;
      m_mis <= {|(m_c2 ^ v), |(m_c1 ^ v), |(m_c0 ^ v)};
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscomp++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic idle();
    in_valid = 1'b0; inj_en = '0; inj_mask = '0;
  endtask

  task automatic lanes_are(string tag, logic [W-1:0] exp);
    chk(tag, 32'(out_lanes), 32'({3{exp}}));
  endtask

  task automatic model_cmp();
    logic [W-1:0] v;
    v = vote3(m_c0, m_c1, m_c2);
    chk("R2 lanes vs model", 32'(out_lanes), 32'({3{v}}));
    chk("R8 flags vs model", 32'(mismatch), 32'(m_mis));
  endtask

  task automatic wait_cnt(int c);
    @(negedge clk);
    while (m_cnt != c) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      miscomp++; vectors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
      $finish;
    end
  end

  initial begin
    // R7: load attempted during reset must be overridden
    in_valid = 1'b1; in_data = 4'hF;
    repeat (3) @(negedge clk);
    lanes_are("R7 reset beats load", 4'h0);
    chk("R7 flags clear", 32'(mismatch), 0);
    chk("R1 ready during reset", 32'(in_ready), 1);
    idle(); rst = 1'b0;

    // R1: load
    @(negedge clk);
    in_valid = 1'b1; in_data = 4'hA;
    @(negedge clk);
    idle();
    lanes_are("R1 load reaches all lanes", 4'hA);
    chk("R1 ready", 32'(in_ready), 1);

    // R4 / R3 / R8: single upset on copy1, right after a tick
    wait_cnt(0);
    inj_en = 3'b010; inj_mask = {4'h0, 4'h1, 4'h0};
    @(negedge clk);
    idle();
    lanes_are("R3 single upset masked", 4'hA);
    chk("R8 flag not yet set", 32'(mismatch), 0);
    @(negedge clk);
    chk("R4 R8 flag marks copy1", 32'(mismatch), 3'b010);

    // R5: after the tick the flag is still set, one edge later it clears
    wait_cnt(0);
    chk("R8 flag holds through tick edge", 32'(mismatch), 3'b010);
    @(negedge clk);
    chk("R5 scrub repaired copy1", 32'(mismatch), 0);
    // second upset same bit on another copy: masked only if scrub worked
    inj_en = 3'b100; inj_mask = {4'h1, 4'h0, 4'h0};
    @(negedge clk);
    idle();
    lanes_are("R5 later upset still masked", 4'hA);

    // R9: double upset on the same bit
    wait_cnt(0);
    inj_en = 3'b011; inj_mask = {4'h0, 4'h2, 4'h2};
    @(negedge clk);
    idle();
    lanes_are("R9 wrong majority wins", 4'h8);
    @(negedge clk);
    chk("R9 flag marks the correct copy", 32'(mismatch), 3'b100);

    // R6: load on the tick cycle
    wait_cnt(SI-2);
    inj_en = 3'b001; inj_mask = {4'h0, 4'h0, 4'h4};
    @(negedge clk);
    idle();
    in_valid = 1'b1; in_data = 4'h5;
    @(negedge clk);
    idle();
    lanes_are("R6 load wins over scrub", 4'h5);
    @(negedge clk);
    chk("R6 all copies loaded", 32'(mismatch), 0);

    // sweep: every data value with every injection pattern
    for (int d = 0; d < 16; d++) begin
      for (int p = 0; p < 8; p++) begin
        @(negedge clk);
        model_cmp();
        in_valid = 1'b1; in_data = W'(d); inj_en = 3'(p);
        inj_mask = {W'((d + 10 + p) % 16), W'((d + 5 + p) % 16), W'((d + p) % 16)};
        @(negedge clk);
        model_cmp();
        idle();
        inj_en = 3'((p * 3) % 8); inj_mask = {W'(p), W'(d), W'(p ^ d)};
        @(negedge clk);
        model_cmp();
        idle();
        for (int k = 0; k < 3; k++) begin
          @(negedge clk);
          model_cmp();
        end
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  end
endmodule